// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block sits between a processor core and the chip's power network. It decides whether a wait request from the core turns into a deep low-power state, and it then watches the wake sources that are valid for that state. There are two deep states. In stop, the core domain keeps its power and the clocks are halted. In standby, the regulator and the core domain are switched off, and the chip returns to run through a reset request.

The core raises three kinds of pulse: interrupt-wait, event-wait, and return-from-handler. The controller checks each pulse against the control bits and the pending-flag vectors. Any pending flag cancels the request without a trace. On a stop entry, the controller records which path was taken and the send-event-on-pending setting. Those two values then pick the wake mask that is applied to the line activity inputs. The exit from stop runs in two steps: the oscillators come back first, and the core clock is released one cycle later together with a one-cycle wake pulse.

Top module: `lp_entry_ctrl`

## Requirements
- R1: After reset the block is in run. `mode_o`=0 (encoding: 0 run, 1 stop, 2 standby, 3 waking), all regulator, power, oscillator, PLL and core-clock enables are 1, `reg_lp_o`=`reg_ud_o`=0, and `wake_o`=`rst_req_o`=0.
- R2: From run, a pulse on `wfi_i` or `wfe_i` with `deep_sleep_i`=1, no pending flag and `pdown_sel_i`=0 moves the block to stop on the next clock edge. With `deep_sleep_i`=0 the pulse is ignored.
- R3: A request is dropped, and the block stays in run, when any bit of `line_pend_i`, `periph_pend_i` or `rtc_flag_i` is set in the request cycle.
- R4: A pulse on `hret_i` enters stop only when `sleep_on_exit_i`=1, `deep_sleep_i`=1 and `pdown_sel_i`=0. With `pdown_sel_i`=1 it is ignored.
- R5: In stop, `reg_en_o`=1, `core_pwr_o`=1, and the core clock, both oscillator enables and all PLL enables are 0. `reg_lp_o` equals `lp_reg_i` as sampled at entry. `reg_ud_o` equals `udrv_en_i & (lp_reg_i ? udrv_lp_i : udrv_main_i)` as sampled at entry.
- R6: After an interrupt-wait or handler-return entry, a line wakes the block only if it is active, set in `line_irq_mode_i` and set in `irq_en_i`.
- R7: After an event-wait entry with `sev_on_pend_i`=0 at entry, a line wakes the block only if it is active and set in `line_evt_mode_i`.
- R8: After an event-wait entry with `sev_on_pend_i`=1 at entry, any active line that is set in `line_irq_mode_i` or in `line_evt_mode_i` wakes the block, whatever `irq_en_i` holds.
- R9: A stop wake gives one cycle with `mode_o`=3, both oscillator enables at 1, the PLLs and the core clock at 0. The next cycle is run with the core clock at 1 and `wake_o`=1, and `wake_o` lasts one cycle only.
- R10: With `pdown_sel_i`=1, a valid interrupt-wait or event-wait request enters standby (`mode_o`=2). In standby the regulator, core power, oscillators, PLLs and core clock are all 0, and line activity has no effect.
- R11: In standby, `stby_wake_i`=1 gives one cycle with `mode_o`=3, `rst_req_o`=1 and `core_pwr_o`=1, and then run. `wake_o` stays 0 during this exit.
- R12: When several pulses arrive together, the recorded entry path follows the priority interrupt-wait, then handler-return, then event-wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wfi_i | input | 1 | Interrupt-wait pulse |
| wfe_i | input | 1 | Event-wait pulse |
| hret_i | input | 1 | Return-from-handler pulse |
| deep_sleep_i | input | 1 | Deep-sleep control bit |
| sleep_on_exit_i | input | 1 | Sleep-on-handler-exit bit |
| pdown_sel_i | input | 1 | 1 selects standby, 0 selects stop |
| sev_on_pend_i | input | 1 | Interrupt lines act as events during an event wait |
| lp_reg_i | input | 1 | Low-power regulator select in stop |
| udrv_en_i | input | 1 | Under-drive enable |
| udrv_main_i | input | 1 | Under-drive on the main regulator |
| udrv_lp_i | input | 1 | Under-drive on the low-power regulator |
| line_pend_i | input | N_LINES | Line pending flags |
| periph_pend_i | input | N_PERIPH | Peripheral pending flags |
| rtc_flag_i | input | N_RTC | Timer alarm, wakeup, tamper and timestamp flags |
| line_act_i | input | N_LINES | Live line activity |
| line_irq_mode_i | input | N_LINES | Line configured in interrupt mode |
| line_evt_mode_i | input | N_LINES | Line configured in event mode |
| irq_en_i | input | N_LINES | Interrupt-controller enable mask |
| stby_wake_i | input | 1 | Standby wake source |
| reg_en_o | output | 1 | Regulator enable |
| reg_lp_o | output | 1 | Low-power regulator active |
| reg_ud_o | output | 1 | Under-drive active |
| core_pwr_o | output | 1 | Core domain power enable |
| core_clk_en_o | output | 1 | Core clock release |
| hsi_en_o | output | 1 | Internal oscillator enable |
| hse_en_o | output | 1 | External oscillator enable |
| pll_en_o | output | N_PLL | PLL enables |
| mode_o | output | 2 | Current mode |
| wake_o | output | 1 | One-cycle wake pulse |
| rst_req_o | output | 1 | Reset request on leaving standby |

## Verification
The bench uses the defaults: eight lines, four peripheral flags, four timer flags and two PLLs. Eight lines are enough to build random mixes in which interrupt-mode, event-mode and enabled lines overlap only in part, so each of the three wake masks gets hits and misses. The narrow pending vectors mean that a single-bit abort is tried often in each of the three groups.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [1:0] {
    ENT_NONE = 2'd0,
    ENT_WFI  = 2'd1,
    ENT_HRET = 2'd2,
    ENT_WFE  = 2'd3
  } entry_e;

  typedef enum logic [2:0] {
    ST_RUN, ST_STOP, ST_STBY, ST_RESUME, ST_RSTREQ
  } pstate_e;

  localparam logic [1:0] MODE_RUN  = 2'd0;
  localparam logic [1:0] MODE_STOP = 2'd1;
  localparam logic [1:0] MODE_STBY = 2'd2;
  localparam logic [1:0] MODE_WAKE = 2'd3;
endpackage

// File: rtl/lp_entry_dec.sv
module lp_entry_dec
  import lp_pkg::*;
#(
  parameter int N_LINES  = 8,
  parameter int N_PERIPH = 4,
  parameter int N_RTC    = 4
) (
  input  logic                wfi_i,
  input  logic                wfe_i,
  input  logic                hret_i,
  input  logic                deep_sleep_i,
  input  logic                sleep_on_exit_i,
  input  logic                pdown_sel_i,
  input  logic [N_LINES-1:0]  line_pend_i,
  input  logic [N_PERIPH-1:0] periph_pend_i,
  input  logic [N_RTC-1:0]    rtc_flag_i,
  output entry_e              code_o,
  output logic                blocked_o,
  output logic                go_stop_o,
  output logic                go_stby_o
);
  logic any_pend, wfi_req, wfe_req, hret_req, go;

  assign any_pend = (|line_pend_i) | (|periph_pend_i) | (|rtc_flag_i);
  assign wfi_req  = wfi_i & deep_sleep_i;
  assign wfe_req  = wfe_i & deep_sleep_i;
  assign hret_req = hret_i & sleep_on_exit_i & deep_sleep_i & ~pdown_sel_i;

  // fixed priority: interrupt-wait, handler-return, event-wait
  always_comb begin
    if (wfi_req)       code_o = ENT_WFI;
    else if (hret_req) code_o = ENT_HRET;
    else if (wfe_req)  code_o = ENT_WFE;
    else               code_o = ENT_NONE;
  end

  assign go        = (code_o != ENT_NONE) & ~any_pend;
  assign blocked_o = (code_o != ENT_NONE) & any_pend;
  assign go_stop_o = go & ~pdown_sel_i;
  assign go_stby_o = go & pdown_sel_i;
endmodule

// File: rtl/lp_wake_mask.sv
module lp_wake_mask
  import lp_pkg::*;
#(
  parameter int N_LINES = 8
) (
  input  entry_e             code_i,
  input  logic               sev_i,
  input  logic [N_LINES-1:0] line_act_i,
  input  logic [N_LINES-1:0] irq_mode_i,
  input  logic [N_LINES-1:0] evt_mode_i,
  input  logic [N_LINES-1:0] irq_en_i,
  output logic               wake_hit_o
);
  logic sel_irq_masked, sel_irq_any, sel_evt;
  logic [N_LINES-1:0] hit_vec;

  assign sel_irq_masked = (code_i == ENT_WFI) | (code_i == ENT_HRET);
  assign sel_evt        = (code_i == ENT_WFE);
  assign sel_irq_any    = sel_evt & sev_i;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    assign hit_vec[g] = line_act_i[g] &
                        ((sel_irq_masked & irq_mode_i[g] & irq_en_i[g]) |
                         (sel_irq_any & irq_mode_i[g]) |
                         (sel_evt & evt_mode_i[g]));
  end

  assign wake_hit_o = |hit_vec;
endmodule

// File: rtl/lp_pwr_fsm.sv
module lp_pwr_fsm
  import lp_pkg::*;
#(
  parameter int N_PLL = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_stop_i,
  input  logic             go_stby_i,
  input  entry_e           code_i,
  input  logic             sev_i,
  input  logic             lp_reg_i,
  input  logic             udrv_en_i,
  input  logic             udrv_main_i,
  input  logic             udrv_lp_i,
  input  logic             wake_hit_i,
  input  logic             stby_wake_i,
  output entry_e           code_q_o,
  output logic             sev_q_o,
  output logic             reg_en_o,
  output logic             reg_lp_o,
  output logic             reg_ud_o,
  output logic             core_pwr_o,
  output logic             core_clk_en_o,
  output logic             hsi_en_o,
  output logic             hse_en_o,
  output logic [N_PLL-1:0] pll_en_o,
  output logic [1:0]       mode_o,
  output logic             wake_o,
  output logic             rst_req_o
);
  pstate_e state_q, state_d;
  logic    lp_q, ud_q, wake_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (go_stby_i) state_d = ST_STBY;
                 else if (go_stop_i) state_d = ST_STOP;
      ST_STOP:   if (wake_hit_i) state_d = ST_RESUME;
      ST_RESUME: state_d = ST_RUN;
      ST_STBY:   if (stby_wake_i) state_d = ST_RSTREQ;
      ST_RSTREQ: state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RUN;
      code_q_o <= ENT_NONE;
      sev_q_o  <= 1'b0;
      lp_q     <= 1'b0;
      ud_q     <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= (state_q == ST_RESUME);
      if (state_q == ST_RUN && go_stop_i && !go_stby_i) begin
        code_q_o <= code_i;
        sev_q_o  <= sev_i;
        lp_q     <= lp_reg_i;
        ud_q     <= udrv_en_i & (lp_reg_i ? udrv_lp_i : udrv_main_i);
      end
    end
  end

  always_comb begin
    reg_en_o      = 1'b1;
    reg_lp_o      = 1'b0;
    reg_ud_o      = 1'b0;
    core_pwr_o    = 1'b1;
    core_clk_en_o = 1'b0;
    hsi_en_o      = 1'b0;
    hse_en_o      = 1'b0;
    pll_en_o      = '0;
    mode_o        = MODE_WAKE;
    rst_req_o     = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        core_clk_en_o = 1'b1;
        hsi_en_o      = 1'b1;
        hse_en_o      = 1'b1;
        pll_en_o      = '1;
        mode_o        = MODE_RUN;
      end
      ST_STOP: begin
        reg_lp_o = lp_q;
        reg_ud_o = ud_q;
        mode_o   = MODE_STOP;
      end
      ST_STBY: begin
        reg_en_o   = 1'b0;
        core_pwr_o = 1'b0;
        mode_o     = MODE_STBY;
      end
      ST_RESUME: begin
        hsi_en_o = 1'b1;
        hse_en_o = 1'b1;
      end
      ST_RSTREQ: begin
        hsi_en_o  = 1'b1;
        rst_req_o = 1'b1;
      end
      default: mode_o = MODE_WAKE;
    endcase
  end

  assign wake_o = wake_q;

  // R9
  wake_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
  // R9
  resume_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RESUME) |=> (mode_o == MODE_RUN && wake_o && core_clk_en_o));
  // R11
  stby_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STBY && stby_wake_i) |=> (rst_req_o && !wake_o && core_pwr_o));
  // R10
  stby_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STBY && !stby_wake_i) |=> (mode_o == MODE_STBY));
  // R5
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && !wake_hit_i) |=> (mode_o == MODE_STOP && $stable(reg_lp_o) && $stable(reg_ud_o)));
endmodule

// File: rtl/lp_entry_ctrl.sv
module lp_entry_ctrl
  import lp_pkg::*;
#(
  parameter int N_LINES  = 8,
  parameter int N_PERIPH = 4,
  parameter int N_RTC    = 4,
  parameter int N_PLL    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wfi_i,
  input  logic                wfe_i,
  input  logic                hret_i,
  input  logic                deep_sleep_i,
  input  logic                sleep_on_exit_i,
  input  logic                pdown_sel_i,
  input  logic                sev_on_pend_i,
  input  logic                lp_reg_i,
  input  logic                udrv_en_i,
  input  logic                udrv_main_i,
  input  logic                udrv_lp_i,
  input  logic [N_LINES-1:0]  line_pend_i,
  input  logic [N_PERIPH-1:0] periph_pend_i,
  input  logic [N_RTC-1:0]    rtc_flag_i,
  input  logic [N_LINES-1:0]  line_act_i,
  input  logic [N_LINES-1:0]  line_irq_mode_i,
  input  logic [N_LINES-1:0]  line_evt_mode_i,
  input  logic [N_LINES-1:0]  irq_en_i,
  input  logic                stby_wake_i,
  output logic                reg_en_o,
  output logic                reg_lp_o,
  output logic                reg_ud_o,
  output logic                core_pwr_o,
  output logic                core_clk_en_o,
  output logic                hsi_en_o,
  output logic                hse_en_o,
  output logic [N_PLL-1:0]    pll_en_o,
  output logic [1:0]          mode_o,
  output logic                wake_o,
  output logic                rst_req_o
);
  entry_e code, code_q;
  logic   blocked, go_stop, go_stby, sev_q, wake_hit;

  lp_entry_dec #(.N_LINES(N_LINES), .N_PERIPH(N_PERIPH), .N_RTC(N_RTC)) u_dec (
    .wfi_i, .wfe_i, .hret_i, .deep_sleep_i, .sleep_on_exit_i, .pdown_sel_i,
    .line_pend_i, .periph_pend_i, .rtc_flag_i,
    .code_o(code), .blocked_o(blocked), .go_stop_o(go_stop), .go_stby_o(go_stby)
  );

  lp_wake_mask #(.N_LINES(N_LINES)) u_mask (
    .code_i(code_q), .sev_i(sev_q), .line_act_i,
    .irq_mode_i(line_irq_mode_i), .evt_mode_i(line_evt_mode_i), .irq_en_i,
    .wake_hit_o(wake_hit)
  );

  lp_pwr_fsm #(.N_PLL(N_PLL)) u_fsm (
    .clk_i, .rst_ni, .go_stop_i(go_stop), .go_stby_i(go_stby), .code_i(code),
    .sev_i(sev_on_pend_i), .lp_reg_i, .udrv_en_i, .udrv_main_i, .udrv_lp_i,
    .wake_hit_i(wake_hit), .stby_wake_i,
    .code_q_o(code_q), .sev_q_o(sev_q),
    .reg_en_o, .reg_lp_o, .reg_ud_o, .core_pwr_o, .core_clk_en_o,
    .hsi_en_o, .hse_en_o, .pll_en_o, .mode_o, .wake_o, .rst_req_o
  );

  // R3
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_RUN && blocked) |=> (mode_o == MODE_RUN));
  // R6
  no_idle_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_STOP && line_act_i == '0) |=> (mode_o == MODE_STOP));
  // R2
  stop_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_RUN && go_stop) |=> (mode_o == MODE_STOP && !core_clk_en_o));
endmodule

// File: tb/lp_entry_ctrl_tb.sv
module lp_entry_ctrl_tb;
  localparam int NL = 8, NP = 4, NR = 4, NPLL = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic wfi, wfe, hret, deep, soe, pdn, sev, lpr, uden, udm, udl, sbw;
  logic [NL-1:0] lpend, act, im, em, en;
  logic [NP-1:0] ppend;
  logic [NR-1:0] rflag;
  logic reg_en, reg_lp, reg_ud, core_pwr, core_clk, hsi, hse, wake, rst_req;
  logic [NPLL-1:0] pll;
  logic [1:0] mode;

  lp_entry_ctrl #(.N_LINES(NL), .N_PERIPH(NP), .N_RTC(NR), .N_PLL(NPLL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wfi_i(wfi), .wfe_i(wfe), .hret_i(hret),
    .deep_sleep_i(deep), .sleep_on_exit_i(soe), .pdown_sel_i(pdn), .sev_on_pend_i(sev),
    .lp_reg_i(lpr), .udrv_en_i(uden), .udrv_main_i(udm), .udrv_lp_i(udl),
    .line_pend_i(lpend), .periph_pend_i(ppend), .rtc_flag_i(rflag),
    .line_act_i(act), .line_irq_mode_i(im), .line_evt_mode_i(em), .irq_en_i(en),
    .stby_wake_i(sbw), .reg_en_o(reg_en), .reg_lp_o(reg_lp), .reg_ud_o(reg_ud),
    .core_pwr_o(core_pwr), .core_clk_en_o(core_clk), .hsi_en_o(hsi), .hse_en_o(hse),
    .pll_en_o(pll), .mode_o(mode), .wake_o(wake), .rst_req_o(rst_req)
  );

  int total = 0, bad = 0;
  logic [1:0] cur_code;
  logic cur_sev;

  task automatic chk(input string req, input logic [31:0] a, input logic [31:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, a, e);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [8:0] pwr_vec();
    return {reg_en, reg_lp, reg_ud, core_pwr, core_clk, hsi, hse, pll};
  endfunction

  localparam logic [8:0] P_RUN = 9'b1_0_0_1_1_1_1_11;
  localparam logic [8:0] P_STBY = 9'b0_0_0_0_0_0_0_00;
  localparam logic [8:0] P_RES = 9'b1_0_0_1_0_1_1_00;
  localparam logic [8:0] P_RST = 9'b1_0_0_1_0_1_0_00;

  function automatic logic [1:0] exp_code(input logic a, b, h, d, s, p);
    if (a && d) return 2'd1;
    if (h && s && d && !p) return 2'd2;
    if (b && d) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic exp_wake(input logic [1:0] c, input logic sv,
                                    input logic [NL-1:0] a, i, e, n);
    case (c)
      2'd1, 2'd2: return |(a & i & n);
      2'd3:       return sv ? |(a & (i | e)) : |(a & e);
      default:    return 1'b0;
    endcase
  endfunction

  task automatic clr();
    wfi = 0; wfe = 0; hret = 0; deep = 0; soe = 0; pdn = 0; sev = 0;
    lpr = 0; uden = 0; udm = 0; udl = 0; sbw = 0;
    lpend = '0; ppend = '0; rflag = '0; act = '0; im = '0; em = '0; en = '0;
  endtask

  // drive a request for one cycle, check resulting mode
  task automatic request(input string req, input logic a, b, h, d, s, p, sv,
                         input logic has_pend, input logic [1:0] exp_mode);
    wfi = a; wfe = b; hret = h; deep = d; soe = s; pdn = p; sev = sv;
    if (has_pend) begin
      case ($urandom % 3)
        0: lpend = NL'(1) << ($urandom % NL);
        1: ppend = NP'(1) << ($urandom % NP);
        default: rflag = NR'(1) << ($urandom % NR);
      endcase
    end
    cur_code = exp_code(a, b, h, d, s, p);
    cur_sev = sv;
    tick();
    wfi = 0; wfe = 0; hret = 0; lpend = '0; ppend = '0; rflag = '0;
    chk(req, 32'(mode), 32'(exp_mode));
  endtask

  // stop-mode wake attempt; returns 1 when woken
  task automatic try_wake(input string req, input logic [NL-1:0] a, i, e, n, output logic hit);
    act = a; im = i; em = e; en = n;
    hit = exp_wake(cur_code, cur_sev, a, i, e, n);
    tick();
    act = '0;
    chk(req, 32'(mode), hit ? 32'd3 : 32'd1);
    if (hit) begin
      chk("R9 resume pwr", 32'(pwr_vec()), 32'(P_RES));
      chk("R9 no early pulse", 32'(wake), 32'd0);
      tick();
      chk("R9 run after resume", 32'(mode), 32'd0);
      chk("R9 wake pulse", 32'(wake), 32'd1);
      chk("R9 run pwr", 32'(pwr_vec()), 32'(P_RUN));
      tick();
      chk("R9 pulse one cycle", 32'(wake), 32'd0);
    end
  endtask

  task automatic stby_exit();
    act = '1; im = '1; em = '1; en = '1;
    tick();
    act = '0;
    chk("R10 lines ignored", 32'(mode), 32'd2);
    chk("R10 standby pwr", 32'(pwr_vec()), 32'(P_STBY));
    sbw = 1;
    tick();
    sbw = 0;
    chk("R11 exit mode", 32'(mode), 32'd3);
    chk("R11 rst_req", 32'(rst_req), 32'd1);
    chk("R11 exit pwr", 32'(pwr_vec()), 32'(P_RST));
    tick();
    chk("R11 back to run", 32'(mode), 32'd0);
    chk("R11 no wake pulse", 32'(wake), 32'd0);
    chk("R11 rst_req drop", 32'(rst_req), 32'd0);
  endtask

  task automatic force_wake();
    logic h;
    try_wake("R6 R7 R8 forced wake", '1, '1, '1, '1, h);
  endtask

  initial begin
    logic h;
    void'($urandom(32'd20240611));
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset mode", 32'(mode), 32'd0);
    chk("R1 reset pwr", 32'(pwr_vec()), 32'(P_RUN));
    chk("R1 reset wake/rst", 32'({wake, rst_req}), 32'd0);

    // R2 no deep sleep -> ignored
    request("R2 no deep sleep", 1, 0, 0, 0, 0, 0, 0, 0, 2'd0);
    // R2 wfi entry with regulator config
    lpr = 1; uden = 1; udl = 1; udm = 0;
    request("R2 wfi stop", 1, 0, 0, 1, 0, 0, 0, 0, 2'd1);
    lpr = 0; uden = 0; udl = 0;
    chk("R5 stop pwr captured", 32'(pwr_vec()), 32'(9'b1_1_1_1_0_0_0_00));
    // R6 interrupt line enabled-mask
    try_wake("R6 irq not enabled", 8'h01, 8'h01, 8'h00, 8'h00, h);
    try_wake("R6 evt-only line", 8'h02, 8'h00, 8'h02, 8'hFF, h);
    try_wake("R6 enabled irq line", 8'h04, 8'h04, 8'h00, 8'h04, h);

    // R3 aborts
    request("R3 pending abort", 1, 0, 0, 1, 0, 0, 0, 1, 2'd0);
    request("R3 pending abort wfe", 0, 1, 0, 1, 0, 0, 0, 1, 2'd0);

    // R4 handler return
    request("R4 hret pdown ignored", 0, 0, 1, 1, 1, 1, 0, 0, 2'd0);
    request("R4 hret no soe", 0, 0, 1, 1, 0, 0, 0, 0, 2'd0);
    request("R4 hret stop", 0, 0, 1, 1, 1, 0, 0, 0, 2'd1);
    try_wake("R6 hret irq masked", 8'h10, 8'h10, 8'h10, 8'h00, h);
    try_wake("R6 hret wake", 8'h10, 8'h10, 8'h00, 8'h10, h);

    // R7 wfe sev=0
    request("R7 wfe stop", 0, 1, 0, 1, 0, 0, 0, 0, 2'd1);
    try_wake("R7 irq line no wake", 8'h20, 8'h20, 8'h00, 8'h20, h);
    try_wake("R7 evt line wake", 8'h40, 8'h00, 8'h40, 8'h00, h);

    // R8 wfe sev=1
    request("R8 wfe sev stop", 0, 1, 0, 1, 0, 0, 1, 0, 2'd1);
    sev = 0;
    try_wake("R8 inactive line", 8'h00, 8'hFF, 8'hFF, 8'h00, h);
    try_wake("R8 disabled irq wakes", 8'h80, 8'h80, 8'h00, 8'h00, h);

    // R12 wfi beats wfe
    request("R12 wfi+wfe stop", 1, 1, 0, 1, 0, 0, 0, 0, 2'd1);
    try_wake("R12 evt line no wake", 8'h08, 8'h00, 8'h08, 8'h00, h);
    try_wake("R12 irq wake", 8'h08, 8'h08, 8'h00, 8'h08, h);

    // R10 standby
    request("R10 standby entry", 1, 0, 0, 1, 0, 1, 0, 0, 2'd2);
    stby_exit();

    // random mix
    for (int it = 0; it < 300; it++) begin
      logic a, b, hr, d, s, p, sv, pe;
      logic [1:0] c, em_exp;
      logic lp0, ud0, um0, ul0;
      a = 1'($urandom); b = 1'($urandom); hr = 1'($urandom);
      d = ($urandom % 4) != 0; s = 1'($urandom); p = ($urandom % 4) == 0;
      sv = 1'($urandom); pe = ($urandom % 4) == 0;
      lp0 = 1'($urandom); ud0 = 1'($urandom); um0 = 1'($urandom); ul0 = 1'($urandom);
      lpr = lp0; uden = ud0; udm = um0; udl = ul0;
      c = exp_code(a, b, hr, d, s, p);
      if (c == 2'd0 || pe) em_exp = 2'd0;
      else if (p) em_exp = 2'd2;
      else em_exp = 2'd1;
      request("R2 R3 R4 R10 random entry", a, b, hr, d, s, p, sv, pe, em_exp);
      lpr = 1'($urandom); uden = 1'($urandom); udm = 1'($urandom); udl = 1'($urandom);
      sev = 1'($urandom);
      if (em_exp == 2'd1) begin
        chk("R5 random stop pwr", 32'(pwr_vec()),
            32'({1'b1, lp0, ud0 & (lp0 ? ul0 : um0), 6'b1_0_0_0_00}));
        h = 0;
        for (int k = 0; k < 3 && !h; k++)
          try_wake("R6 R7 R8 random wake", NL'($urandom), NL'($urandom),
                   NL'($urandom), NL'($urandom), h);
        if (!h) force_wake();
      end else if (em_exp == 2'd2) begin
        stby_exit();
      end
      clr();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule